// File: doc/BRIEF.md
# Lock Qualification and Stall Shutdown Supervisor

This block sits between a speed-control loop and the three-phase output stage of a motor driver. It takes the loop's raw lock indication and turns it into a lock-detect output that only asserts once lock has been held without a break for a programmable number of clock ticks. The delay hides the short lock pulses that appear while the loop hunts during pull-in. A configuration input can bypass this delay entirely.

In parallel, a stall timer watches the motor while the run input is high. It can be set to watch either the qualified lock output or transitions of the speed-feedback (FG) pulse. If the watched condition stays bad for the protection time, the block latches a shutdown that forces every upper-side switch command off. The latch holds until run is dropped or reset is applied. A slowdown input holds the timer at zero so that a deliberate deceleration toward a lower reference frequency never trips the protection. Because an absent reference clock leaves the loop unlocked, the same timer also acts as clock-loss protection. All analog timing is expressed as clock-tick parameters. The asynchronous reset is released synchronously, and all logic stays cleared for as long as reset is held.

Top module: `spin_guard`

## Requirements
- R1: While `rst_n` is low, and for two clock edges after it rises, `lock_det` and `stall_trip` are 0 and `hs_out` equals `hs_cmd`. Asserting `rst_n` low at any time clears both outputs at once.
- R2: With `mask_en` = 1, `lock_det` rises at the clock edge that samples `lock_raw` high for the MASK_TICKS-th consecutive time. It is visible in the cycle after that edge.
- R3: A clock edge that samples `lock_raw` low clears `lock_det` and restarts the mask count. Lock pulses shorter than MASK_TICKS samples are therefore never reported.
- R4: With `mask_en` = 0, `lock_det` rises at the first edge that samples `lock_raw` high.
- R5: With `src_sel` = 1 (lock source) and `run` = 1, `stall_trip` sets after STALL_TICKS consecutive edges at which `lock_det` was 0. Any edge with `lock_det` = 1 restarts the count.
- R6: With `src_sel` = 0 (FG source) and `run` = 1, `stall_trip` sets after STALL_TICKS consecutive edges with no FG transition. A transition is an edge at which `fg_in` differs from its value at the previous edge.
- R7: While `stall_trip` = 1, `hs_out` is 0 on all three bits. Otherwise `hs_out` equals `hs_cmd`, bit i driving the upper switch of phase i.
- R8: Once set, `stall_trip` stays 1 while `run` = 1, whatever `lock_raw`, `fg_in`, `decel` and `src_sel` do.
- R9: An edge that samples `run` = 0 clears `stall_trip` and the stall count.
- R10: An edge that samples `decel` = 1 while `run` = 1 and no trip is latched resets the stall count to zero. Holding `decel` high therefore prevents a trip.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on reset) |
| run | input | 1 | 1 = run, 0 = stop |
| lock_raw | input | 1 | Unqualified lock indication from the speed loop |
| mask_en | input | 1 | 1 = apply the lock mask delay, 0 = bypass it |
| src_sel | input | 1 | Stall source: 1 = lost lock, 0 = missing FG transitions |
| fg_in | input | 1 | Speed-feedback pulse, synchronous to clk |
| decel | input | 1 | Deceleration in progress (speed above target) |
| hs_cmd | input | 3 | Upper-side switch commands from commutation |
| hs_out | output | 3 | Gated upper-side switch commands |
| lock_det | output | 1 | Qualified lock-detect output |
| stall_trip | output | 1 | Latched stall-protection shutdown |

## Verification
The assertions assume that every input is synchronous to `clk`, with `fg_in` and `lock_raw` already free of metastability upstream. They also assume `mask_en` is not raised while `lock_raw` is high, since doing so would leave an already reported lock standing. The stimulus changes inputs only just after a rising edge. It alters `mask_en` only while `lock_raw` is low, and it toggles `fg_in` no faster than once per clock. Mode changes of `src_sel` are made while the trip is latched or while `run` is low, so each stall window starts from a known count.

// File: rtl/spg_pkg.sv
package spg_pkg;
  typedef enum logic {
    SRC_FG   = 1'b0,
    SRC_LOCK = 1'b1
  } stall_src_e;

  localparam int unsigned PHASES = 3;
endpackage

// File: rtl/spg_rst_sync.sv
module spg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/spg_lock_mask.sv
module spg_lock_mask #(
  parameter int unsigned MASK_TICKS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_raw,
  input  logic mask_en,
  output logic lock_det
);
  localparam int unsigned CW = $clog2(MASK_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(MASK_TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          det_d;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    det_d  = lock_det;
    if (!lock_raw) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
      det_d  = 1'b0;
    end else begin
      if (cnt_q != LAST) begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q + 1'b1;
      end
      if (!mask_en || (cnt_q == LAST)) det_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      lock_det <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      lock_det <= det_d;
    end
  end

  // R3
  drop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_raw |=> !lock_det);

  // R2
  rise_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_det) |-> $past(lock_raw));
endmodule

// File: rtl/spg_stall_timer.sv
module spg_stall_timer
  import spg_pkg::*;
#(
  parameter int unsigned STALL_TICKS = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  stall_src_e src,
  input  logic       lock_det,
  input  logic       fg_in,
  input  logic       decel,
  output logic       trip
);
  localparam int unsigned CW = $clog2(STALL_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(STALL_TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          trip_d;
  logic          fg_prev_q;
  logic          fg_edge;
  logic          alive;

  assign fg_edge = fg_in ^ fg_prev_q;

  always_comb begin
    alive  = (src == SRC_LOCK) ? lock_det : fg_edge;
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    trip_d = trip;
    if (!run) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
      trip_d = 1'b0;
    end else if (!trip) begin
      if (decel || alive) begin
        cnt_en = 1'b1;
        cnt_d  = '0;
      end else if (cnt_q == LAST) begin
        trip_d = 1'b1;
      end else begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      trip      <= 1'b0;
      fg_prev_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      trip      <= trip_d;
      fg_prev_q <= fg_in;
    end
  end

  // R8
  trip_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trip && run) |=> trip);

  // R9
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !trip);

  // R10
  decel_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !trip && decel) |=> !trip);
endmodule

// File: rtl/spin_guard.sv
module spin_guard
  import spg_pkg::*;
#(
  parameter int unsigned MASK_TICKS  = 1000,
  parameter int unsigned STALL_TICKS = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              lock_raw,
  input  logic              mask_en,
  input  logic              src_sel,
  input  logic              fg_in,
  input  logic              decel,
  input  logic [PHASES-1:0] hs_cmd,
  output logic [PHASES-1:0] hs_out,
  output logic              lock_det,
  output logic              stall_trip
);
  logic       rst_sync_n;
  stall_src_e src;

  assign src = stall_src_e'(src_sel);

  spg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  spg_lock_mask #(.MASK_TICKS(MASK_TICKS)) u_mask (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .lock_raw (lock_raw),
    .mask_en  (mask_en),
    .lock_det (lock_det)
  );

  spg_stall_timer #(.STALL_TICKS(STALL_TICKS)) u_stall (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (run),
    .src      (src),
    .lock_det (lock_det),
    .fg_in    (fg_in),
    .decel    (decel),
    .trip     (stall_trip)
  );

  for (genvar p = 0; p < PHASES; p++) begin : g_gate
    assign hs_out[p] = hs_cmd[p] & ~stall_trip;
  end

  // R7
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    stall_trip |-> (hs_out == '0));
endmodule

// File: tb/spin_guard_tb_top.sv
module spin_guard_tb_top;
  localparam int M = 12;
  localparam int T = 40;

  logic       clk = 1'b0;
  logic       rst_n, run, lock_raw, mask_en, src_sel, fg_in, decel;
  logic [2:0] hs_cmd;
  logic [2:0] hs_out;
  logic       lock_det, stall_trip;

  spin_guard #(.MASK_TICKS(M), .STALL_TICKS(T)) dut_i (
    .clk(clk), .rst_n(rst_n), .run(run), .lock_raw(lock_raw),
    .mask_en(mask_en), .src_sel(src_sel), .fg_in(fg_in), .decel(decel),
    .hs_cmd(hs_cmd), .hs_out(hs_out), .lock_det(lock_det),
    .stall_trip(stall_trip)
  );

  always #10 clk = ~clk;

  int    checks = 0;
  int    fails  = 0;
  bit    started = 0;
  bit    done = 0;
  string cur_req = "R1";

  // behavioural reference state
  int rel, h, s;
  bit m_lock, m_trip, m_fgp, evt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel = 0; h = 0; s = 0; m_lock = 0; m_trip = 0; m_fgp = 0;
    end else if (rel < 2) begin
      rel++; h = 0; s = 0; m_lock = 0; m_trip = 0; m_fgp = 0;
    end else begin
      evt = src_sel ? m_lock : (fg_in != m_fgp);
      if (!run) begin
        s = 0; m_trip = 0;
      end else if (!m_trip) begin
        if (decel || evt) s = 0;
        else if (s == T - 1) m_trip = 1;
        else s++;
      end
      m_fgp = fg_in;
      if (!lock_raw) begin
        h = 0; m_lock = 0;
      end else begin
        if (!mask_en || h >= M - 1) m_lock = 1;
        if (h < M) h++;
      end
    end
    if (rst_n) started = 1;
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk("lock_det", int'(lock_det), int'(m_lock));
      chk("stall_trip", int'(stall_trip), int'(m_trip));
      chk("hs_out", int'(hs_out), m_trip ? 0 : int'(hs_cmd));
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      hs_cmd = hs_cmd + 3'd1;
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; run = 0; lock_raw = 0; mask_en = 1; src_sel = 1;
    fg_in = 0; decel = 0; hs_cmd = 3'd0;
    // R1: held reset and synchronous release
    cur_req = "R1";
    tick(4);
    rst_n = 1;
    tick(4);
    // R2: mask delay with steady lock, stopped so no trip
    cur_req = "R2";
    lock_raw = 1;
    tick(20);
    // R3: hunting pulses shorter than mask are hidden, drop clears
    cur_req = "R3";
    lock_raw = 0;
    tick(3);
    repeat (4) begin
      lock_raw = 1; tick(8);
      lock_raw = 0; tick(3);
    end
    lock_raw = 1; tick(15);
    lock_raw = 0; tick(2);
    // R4: mask bypassed
    cur_req = "R4";
    mask_en = 0;
    repeat (3) begin
      lock_raw = 1; tick(2);
      lock_raw = 0; tick(2);
    end
    mask_en = 1;
    tick(2);
    // R5 and R7: lock source, never locks, trip gates commands
    cur_req = "R5";
    run = 1;
    tick(45);
    cur_req = "R7";
    tick(8);
    // R8: latch survives activity
    cur_req = "R8";
    lock_raw = 1; tick(20);
    repeat (5) begin fg_in = ~fg_in; tick(1); end
    decel = 1; src_sel = 0; tick(5);
    // R9: stop clears latch
    cur_req = "R9";
    run = 0; tick(2);
    lock_raw = 0; decel = 0; src_sel = 1; run = 1;
    tick(10);
    // R6: FG source, toggles keep it alive, then silence trips it
    cur_req = "R6";
    run = 0; tick(1);
    src_sel = 0; run = 1;
    repeat (8) begin fg_in = ~fg_in; tick(10); end
    tick(50);
    run = 0; tick(1); run = 1;
    // R10: deceleration holds the counter at zero
    cur_req = "R10";
    decel = 1; tick(80);
    decel = 0; tick(45);
    // R1: asynchronous reset in mid run
    cur_req = "R1";
    rst_n = 0; tick(3);
    rst_n = 1; tick(4);
    // R5: steady lock in lock-source mode never trips
    cur_req = "R5";
    src_sel = 1; lock_raw = 1;
    tick(100);
    done = 1;
    summary();
    $finish;
  end
endmodule